// File: doc/BRIEF.md
# DMA Read Request Header Decoder

This block watches a 32-bit request bus running from an IO bridge towards a cache and picks out DMA read requests. A DMA read request takes two back-to-back beats. The first beat is the header. It holds a fixed command code, a direction bit, a slot index, a scattered packet tag and the top eight address bits. The beat in the very next cycle holds the low 32 address bits.

The decoder joins the two beats into a 40-bit address and a 9-bit tag, then files them in a table entry picked by the slot index. A tracking agent reads the table through a combinational lookup port and sees which entries are occupied from a per-entry valid vector. It frees an entry with a release strobe.

An entry can only be written while it is free. A finished record whose target entry is occupied waits in a one-deep holding register until that entry is released. The request bus is a pure monitor and has no ready signal, so it cannot be back-pressured. A read header that arrives while the holding register is still blocked is dropped, and a sticky overflow flag records the loss.

Top module: `dmard_decoder`

## Requirements
- R1: A beat is a read header only when `req_valid` is 1, bits [31:24] equal 8'h49 and bit 23 is 0. A beat with bit 23 set, with another code, or with `req_valid` low never creates a table entry.
- R2: The bus value in the cycle right after a read header is taken as address bits [31:0], whatever `req_valid` is. That beat is never decoded as a header.
- R3: The fields map as follows:
  - address[39:32] comes from header[7:0]
  - tag[4:0] comes from header[13:9]
  - tag[8] comes from header[8]
  - tag[7:5] is 0
  - the slot index is the low log2(ENTRIES) bits of header[18:14].
- R4: When the target entry is free, the entry becomes valid at the clock edge that follows the edge sampling the address beat. It does not become valid earlier, and at most one entry becomes valid per cycle.
- R5: When the target entry is occupied, the finished record is held unchanged and the entry keeps its old contents. The record is written at the first edge at which the entry is seen free.
- R6: `rel_en` clears entry `rel_idx` at the next edge, and releasing a free entry has no other effect. If a held record is written into the same entry at that same edge, the write wins.
- R7: A read header seen while the held record cannot be written in that cycle sets `ovf_flag`. That header and its address beat are discarded. `ovf_flag` clears only on reset.
- R8: `lk_addr` and `lk_tag` show the stored contents of entry `lk_idx` in the same cycle.
- R9: After reset, every entry is invalid, `ovf_flag` is 0 and the decoder waits for a header.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request bus beat valid |
| req_data | input | 32 | Request bus beat |
| rel_en | input | 1 | Release strobe |
| rel_idx | input | log2(ENTRIES) | Entry to release |
| lk_idx | input | log2(ENTRIES) | Lookup entry index |
| lk_addr | output | 40 | Stored address of entry `lk_idx` |
| lk_tag | output | 9 | Stored packet tag of entry `lk_idx` |
| ent_valid | output | ENTRIES | Per-entry occupied bits |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The bench uses the default of 32 entries, so the slot field decodes in full and every entry can be reached. Random headers pick most slots from a small low group, so they often land on occupied entries. This exercises stalls, releases that unblock a held record, and overflow from a second header. Directed cases cover the other situations: an address beat that looks like a header, write and foreign commands, a release that coincides with a write, and the exact cycle in which an entry turns valid.

// File: rtl/dmard_pkg.sv
package dmard_pkg;
  localparam int ADDR_W   = 40;
  localparam int TAG_W    = 9;
  localparam int BEAT_W   = 32;
  localparam int HI_W     = ADDR_W - BEAT_W;
  localparam logic [7:0] READ_CODE = 8'h49;
  // header field positions
  localparam int CODE_LSB = 24;
  localparam int DIR_BIT  = 23;
  localparam int SLOT_LSB = 14;
  localparam int SLOT_W   = 5;
  localparam int TLO_LSB  = 9;
  localparam int TLO_W    = 5;
  localparam int THI_BIT  = 8;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [TAG_W-1:0]  tag;
  } dmard_rec_t;

  typedef enum logic {PH_HDR = 1'b0, PH_ADDR = 1'b1} dmard_phase_e;
endpackage

// File: rtl/dmard_hdr_parse.sv
module dmard_hdr_parse
  import dmard_pkg::*;
#(
  parameter int ENTRIES = 32,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [BEAT_W-1:0] req_data,
  input  logic              pend_busy,
  output logic              rec_vld,
  output dmard_rec_t        rec,
  output logic [IDX_W-1:0]  rec_idx,
  output logic              ovf_evt
);
  dmard_phase_e     phase_q;
  logic [HI_W-1:0]  hi_q;
  logic [TAG_W-1:0] tag_q;
  logic [IDX_W-1:0] idx_q;
  logic             hdr_hit;
  logic             accept;

  assign hdr_hit = (phase_q == PH_HDR) && req_valid
                && (req_data[CODE_LSB +: 8] == READ_CODE)
                && !req_data[DIR_BIT];
  assign accept  = hdr_hit && !pend_busy;
  assign ovf_evt = hdr_hit && pend_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_HDR;
    end else if (phase_q == PH_ADDR) begin
      phase_q <= PH_HDR;
    end else if (accept) begin
      phase_q <= PH_ADDR;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q  <= '0;
      tag_q <= '0;
      idx_q <= '0;
    end else if (accept) begin
      hi_q  <= req_data[HI_W-1:0];
      tag_q <= {req_data[THI_BIT], 3'b000, req_data[TLO_LSB +: TLO_W]};
      idx_q <= req_data[SLOT_LSB +: IDX_W];
    end
  end

  assign rec_vld  = (phase_q == PH_ADDR);
  assign rec.addr = {hi_q, req_data};
  assign rec.tag  = tag_q;
  assign rec_idx  = idx_q;
endmodule

// File: rtl/dmard_stall_buf.sv
module dmard_stall_buf
  import dmard_pkg::*;
#(
  parameter int ENTRIES = 32,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_vld,
  input  dmard_rec_t       in_rec,
  input  logic [IDX_W-1:0] in_idx,
  input  logic             tgt_occupied,
  output logic             pend_vld,
  output dmard_rec_t       pend_rec,
  output logic [IDX_W-1:0] pend_idx,
  output logic             wr_en,
  output logic             busy
);
  assign wr_en = pend_vld && !tgt_occupied;
  assign busy  = pend_vld && !wr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_vld <= 1'b0;
    end else if (in_vld) begin
      pend_vld <= 1'b1;
    end else if (wr_en) begin
      pend_vld <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_rec <= '0;
      pend_idx <= '0;
    end else if (in_vld) begin
      pend_rec <= in_rec;
      pend_idx <= in_idx;
    end
  end
endmodule

// File: rtl/dmard_slot_table.sv
module dmard_slot_table
  import dmard_pkg::*;
#(
  parameter int ENTRIES = 32,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  dmard_rec_t         wr_rec,
  input  logic               rel_en,
  input  logic [IDX_W-1:0]   rel_idx,
  input  logic [IDX_W-1:0]   rd_idx,
  output dmard_rec_t         rd_rec,
  output logic [ENTRIES-1:0] valid
);
  dmard_rec_t rec_arr [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic       v_q;
    dmard_rec_t d_q;
    logic       hit_wr;
    logic       hit_rel;

    assign hit_wr  = wr_en  && (wr_idx  == IDX_W'(g));
    assign hit_rel = rel_en && (rel_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
      end else if (hit_wr) begin
        v_q <= 1'b1;
      end else if (hit_rel) begin
        v_q <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (hit_wr) begin
        d_q <= wr_rec;
      end
    end

    assign valid[g]   = v_q;
    assign rec_arr[g] = d_q;
  end

  assign rd_rec = rec_arr[rd_idx];
endmodule

// File: rtl/dmard_decoder.sv
module dmard_decoder
  import dmard_pkg::*;
#(
  parameter int ENTRIES = 32,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [31:0]        req_data,
  input  logic               rel_en,
  input  logic [IDX_W-1:0]   rel_idx,
  input  logic [IDX_W-1:0]   lk_idx,
  output logic [39:0]        lk_addr,
  output logic [8:0]         lk_tag,
  output logic [ENTRIES-1:0] ent_valid,
  output logic               ovf_flag
);
  logic             rec_vld;
  dmard_rec_t       rec;
  logic [IDX_W-1:0] rec_idx;
  logic             ovf_evt;
  logic             pend_vld;
  dmard_rec_t       pend_rec;
  logic [IDX_W-1:0] pend_idx;
  logic             wr_en;
  logic             pend_busy;
  dmard_rec_t       lk_rec;

  dmard_hdr_parse #(.ENTRIES(ENTRIES)) parse_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_data(req_data),
    .pend_busy(pend_busy), .rec_vld(rec_vld), .rec(rec), .rec_idx(rec_idx),
    .ovf_evt(ovf_evt)
  );

  dmard_stall_buf #(.ENTRIES(ENTRIES)) hold_i (
    .clk(clk), .rst_n(rst_n), .in_vld(rec_vld), .in_rec(rec), .in_idx(rec_idx),
    .tgt_occupied(ent_valid[pend_idx]), .pend_vld(pend_vld), .pend_rec(pend_rec),
    .pend_idx(pend_idx), .wr_en(wr_en), .busy(pend_busy)
  );

  dmard_slot_table #(.ENTRIES(ENTRIES)) table_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(pend_idx), .wr_rec(pend_rec),
    .rel_en(rel_en), .rel_idx(rel_idx), .rd_idx(lk_idx), .rd_rec(lk_rec),
    .valid(ent_valid)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_flag <= 1'b0;
    end else if (ovf_evt) begin
      ovf_flag <= 1'b1;
    end
  end

  assign lk_addr = lk_rec.addr;
  assign lk_tag  = lk_rec.tag;
endmodule

// File: rtl/dmard_decoder_chk.sv
module dmard_decoder_chk
  import dmard_pkg::*;
#(
  parameter int ENTRIES = 32,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               rel_en,
  input logic [IDX_W-1:0]   rel_idx,
  input logic [ENTRIES-1:0] ent_valid,
  input logic               ovf_flag,
  input logic               wr_en,
  input logic [IDX_W-1:0]   wr_idx,
  input logic               pend_vld,
  input dmard_rec_t         pend_rec
);
  assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag |=> ovf_flag);

  assert_rise_needs_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((ent_valid & ~$past(ent_valid)) != '0) |-> $past(wr_en));

  assert_one_fill_per_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ent_valid) <= $past($countones(ent_valid)) + 1);

  assert_hold_stalled_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_vld && !wr_en) |=> (pend_vld && $stable(pend_rec) && $stable(wr_idx)));

  assert_release_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_en && !(wr_en && wr_idx == rel_idx)) |=> !ent_valid[$past(rel_idx)]);
endmodule

bind dmard_decoder dmard_decoder_chk #(.ENTRIES(ENTRIES)) chk_i (
  .clk(clk), .rst_n(rst_n), .rel_en(rel_en), .rel_idx(rel_idx),
  .ent_valid(ent_valid), .ovf_flag(ovf_flag), .wr_en(wr_en), .wr_idx(pend_idx),
  .pend_vld(pend_vld), .pend_rec(pend_rec)
);

// File: tb/dmard_decoder_tb_top.sv
module dmard_decoder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ENTRIES = 32;
  localparam int IDX_W = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [31:0] req_data = '0;
  logic rel_en = 1'b0;
  logic [IDX_W-1:0] rel_idx = '0;
  logic [IDX_W-1:0] lk_idx = '0;
  logic [39:0] lk_addr;
  logic [8:0] lk_tag;
  logic [ENTRIES-1:0] ent_valid;
  logic ovf_flag;

  int n_checks = 0;
  int n_errors = 0;
  bit mdl_on = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dmard_decoder #(.ENTRIES(ENTRIES)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_data(req_data),
    .rel_en(rel_en), .rel_idx(rel_idx), .lk_idx(lk_idx), .lk_addr(lk_addr),
    .lk_tag(lk_tag), .ent_valid(ent_valid), .ovf_flag(ovf_flag)
  );

  function automatic logic [31:0] mk_hdr(input logic wr, input logic [4:0] slot,
                                         input logic [4:0] tlo, input logic t8,
                                         input logic [7:0] hi);
    return {8'h49, wr, 4'h0, slot, tlo, t8, hi};
  endfunction

  function automatic logic [8:0] exp_tag(input logic [4:0] tlo, input logic t8);
    return {t8, 3'b000, tlo};
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference model built from the requirements
  logic       m_ph, m_pv, m_ovf;
  logic [7:0] m_hi;
  logic [8:0] m_htag, m_ptag;
  logic [4:0] m_hslot, m_pslot;
  logic [39:0] m_paddr;
  logic       m_val [ENTRIES];
  logic [39:0] m_addr [ENTRIES];
  logic [8:0] m_tag [ENTRIES];

  always @(posedge clk) begin
    logic commit, busy;
    if (!rst_n) begin
      m_ph = 1'b0; m_pv = 1'b0; m_ovf = 1'b0;
      for (int i = 0; i < ENTRIES; i++) m_val[i] = 1'b0;
    end else begin
      commit = m_pv && !m_val[m_pslot];
      busy = m_pv && !commit;
      if (rel_en) m_val[rel_idx] = 1'b0;
      if (commit) begin
        m_val[m_pslot] = 1'b1; m_addr[m_pslot] = m_paddr;
        m_tag[m_pslot] = m_ptag; m_pv = 1'b0;
      end
      if (m_ph) begin
        m_pv = 1'b1; m_paddr = {m_hi, req_data}; m_ptag = m_htag;
        m_pslot = m_hslot; m_ph = 1'b0;
      end else if (req_valid && req_data[31:24] == 8'h49 && !req_data[23]) begin
        if (busy) m_ovf = 1'b1;
        else begin
          m_ph = 1'b1; m_hi = req_data[7:0];
          m_htag = {req_data[8], 3'b000, req_data[13:9]};
          m_hslot = req_data[18:14];
        end
      end
    end
  end

  always @(negedge clk) begin
    logic [ENTRIES-1:0] mv;
    if (rst_n && mdl_on) begin
      for (int i = 0; i < ENTRIES; i++) mv[i] = m_val[i];
      check(ent_valid == mv, "R5 valid vector vs model", 64'(ent_valid), 64'(mv));
      check(ovf_flag == m_ovf, "R7 overflow vs model", 64'(ovf_flag), 64'(m_ovf));
      if (m_val[lk_idx]) begin
        check(lk_addr == m_addr[lk_idx], "R8 lookup addr vs model", 64'(lk_addr), 64'(m_addr[lk_idx]));
        check(lk_tag == m_tag[lk_idx], "R3 lookup tag vs model", 64'(lk_tag), 64'(m_tag[lk_idx]));
      end
    end
  end

  task automatic step(input logic v, input logic [31:0] d,
                      input logic re = 1'b0, input logic [4:0] ri = '0);
    @(posedge clk); #1;
    req_valid = v; req_data = d; rel_en = re; rel_idx = ri;
  endtask

  task automatic look(input logic [4:0] idx);
    lk_idx = idx; #1;
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst_n = 1'b0; req_valid = 1'b0; rel_en = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++; n_errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    logic [ENTRIES-1:0] snap;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    mdl_on = 1'b1;
    #1;
    check(ent_valid == '0, "R9 reset valid", 64'(ent_valid), 64'h0);
    check(ovf_flag == 1'b0, "R9 reset ovf", 64'(ovf_flag), 64'h0);

    // R3 / R4 basic read into slot 5
    step(1, mk_hdr(0, 5'd5, 5'h13, 1'b1, 8'hA5));
    step(0, 32'h12345678);
    step(0, 32'h0);
    check(ent_valid[5] == 1'b0, "R4 not valid before fill edge", 64'(ent_valid[5]), 64'h0);
    step(0, 32'h0);
    check(ent_valid[5] == 1'b1, "R4 valid at fill edge", 64'(ent_valid[5]), 64'h1);
    look(5);
    check(lk_addr == 40'hA512345678, "R3 address assembly", 64'(lk_addr), 64'hA512345678);
    check(lk_tag == exp_tag(5'h13, 1'b1), "R3 tag assembly", 64'(lk_tag), 64'(exp_tag(5'h13, 1'b1)));

    // R1 write, foreign code, valid low
    step(1, mk_hdr(1, 5'd9, 5'h1, 1'b0, 8'h11)); step(0, 32'h0); step(0, 32'h0); step(0, 32'h0);
    step(1, {8'h48, mk_hdr(0, 5'd9, 5'h1, 1'b0, 8'h11)}[31:0] & 32'h48FFFFFF);
    step(0, 32'h0); step(0, 32'h0); step(0, 32'h0);
    step(0, mk_hdr(0, 5'd9, 5'h2, 1'b0, 8'h22)); step(0, 32'h0); step(0, 32'h0); step(0, 32'h0);
    check(ent_valid[9] == 1'b0, "R1 non-read beats ignored", 64'(ent_valid[9]), 64'h0);

    // R2 address beat shaped like a header
    step(1, mk_hdr(0, 5'd10, 5'h4, 1'b0, 8'h01));
    step(1, mk_hdr(0, 5'd11, 5'h7, 1'b1, 8'h77));
    step(0, 32'h0); step(0, 32'h0); step(0, 32'h0);
    check(ent_valid[10] == 1'b1 && ent_valid[11] == 1'b0, "R2 second beat not decoded",
          64'({ent_valid[11], ent_valid[10]}), 64'h1);
    look(10);
    check(lk_addr == {8'h01, mk_hdr(0, 5'd11, 5'h7, 1'b1, 8'h77)}, "R2 low address from beat",
          64'(lk_addr), 64'({8'h01, mk_hdr(0, 5'd11, 5'h7, 1'b1, 8'h77)}));

    // R6 release of a free entry, and write wins over release
    snap = ent_valid;
    step(0, 32'h0, 1'b1, 5'd20); step(0, 32'h0); step(0, 32'h0);
    check(ent_valid == snap, "R6 release of free entry", 64'(ent_valid), 64'(snap));
    step(1, mk_hdr(0, 5'd14, 5'h3, 1'b0, 8'h0E));
    step(0, 32'hCAFE0000);
    step(0, 32'h0, 1'b1, 5'd14);
    step(0, 32'h0);
    check(ent_valid[14] == 1'b1, "R6 write beats coincident release", 64'(ent_valid[14]), 64'h1);

    // R5 stall on occupied slot 5, R7 overflow
    step(1, mk_hdr(0, 5'd5, 5'h01, 1'b0, 8'h3C));
    step(0, 32'hDEADBEEF);
    step(0, 32'h0); step(0, 32'h0); step(0, 32'h0);
    look(5);
    check(lk_addr == 40'hA512345678, "R5 occupied entry keeps contents", 64'(lk_addr), 64'hA512345678);
    step(1, mk_hdr(0, 5'd12, 5'h02, 1'b0, 8'h12));
    step(0, 32'h0);
    check(ovf_flag == 1'b1, "R7 overflow set", 64'(ovf_flag), 64'h1);
    step(0, 32'h0, 1'b1, 5'd5);
    step(0, 32'h0);
    check(ent_valid[5] == 1'b0, "R6 release clears", 64'(ent_valid[5]), 64'h0);
    step(0, 32'h0);
    look(5);
    check(ent_valid[5] == 1'b1 && lk_addr == 40'h3CDEADBEEF, "R5 held record written after release",
          64'(lk_addr), 64'h3CDEADBEEF);
    step(0, 32'h0); step(0, 32'h0);
    check(ent_valid[12] == 1'b0, "R7 dropped header leaves no entry", 64'(ent_valid[12]), 64'h0);
    check(ovf_flag == 1'b1, "R7 flag sticky", 64'(ovf_flag), 64'h1);

    // random phase with fixed seed
    do_reset();
    #1;
    check(ent_valid == '0 && ovf_flag == 1'b0, "R9 second reset", 64'({ovf_flag, ent_valid}), 64'h0);
    void'($urandom(32'd1234));
    for (int n = 0; n < 4000; n++) begin
      int sel;
      logic [4:0] slot;
      sel = $urandom_range(0, 99);
      slot = ($urandom_range(0, 3) == 0) ? 5'($urandom_range(0, 31)) : 5'($urandom_range(0, 5));
      lk_idx = 5'($urandom_range(0, 31));
      if (sel < 35)
        step(1, mk_hdr(0, slot, 5'($urandom), 1'($urandom), 8'($urandom)),
             ($urandom_range(0, 4) == 0), 5'($urandom_range(0, 7)));
      else if (sel < 45)
        step(1, mk_hdr(1, slot, 5'($urandom), 1'($urandom), 8'($urandom)));
      else
        step(1'($urandom), $urandom, ($urandom_range(0, 3) == 0), 5'($urandom_range(0, 7)));
      if (ovf_flag && $urandom_range(0, 50) == 0) do_reset();
    end
    step(0, 32'h0);
    repeat (2) @(posedge clk);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule